// File: doc/BRIEF.md
# Ultra-DMA Operation Control and Status Registers

This block is the register front end of an Ultra-DMA transfer engine. A host reaches four 32-bit registers over a simple single-cycle read/write bus: the device-bus control register, the transfer configuration register, the operation register and the status register. The control register drives the device strobes, chip selects and register address lines. The configuration register selects the transfer family, the mode number and the write hold count. The operation register holds the transfer direction and the enable.

The enable is guarded by a fixed arming order. First the host writes the direction with the enable clear. Then it reads the operation register back. Only then does a write with the enable set take effect. An enabling write that breaks this order is dropped and raises a sticky sequence-error flag. Clearing the enable while a transfer runs stops it, and the same edge forces the device strobes and chip selects back to their idle (high) level.

The transfer state machine reports request, busy, interrupt and three error conditions. The block captures these together with the device interrupt pin. It also condenses them into a two-bit prioritised state code, so the host can poll a single field.

Top module: `udma_opstat_regs`

## Requirements
- R1: After synchronous reset, op_enable, op_to_device, dma_state, all config outputs and the sequence-error flag are 0; the control register reads 0x63: ata_cs_n=2'b11, ata_da=0, ata_rd_n=1, ata_wr_n=1.
- R2: A read (rd_en high, wr_en low) returns rdata with rvalid high on the cycle after the request edge. Byte offset 0x0 selects control, 0x4 configuration, 0x8 operation and 0xC status. Any other address reads zero and ignores writes.
- R3: The control register places chip select 0 at bit 0, chip select 1 at bit 1, the register address at bits 4:2, the read strobe at bit 5 and the write strobe at bit 6, all active low. Each field drives its port after the write edge. Bit 9 reads the captured device interrupt pin.
- R4: The configuration register holds the enable, PIO, multiword and Ultra flags at bits 0 to 3, the mode number at bits 7:4 and the hold count at bits 9:8. Its other bits read zero.
- R5: The operation register places the enable at bit 0 and the direction at bit 1 (1 = toward the device). Writing the direction with bit 0 clear, then reading the operation register, then writing bit 0 set with the same direction sets op_enable.
- R6: An operation write with bit 0 set is ignored and leaves op_enable unchanged in these cases: the readback step is missing, the direction differs, a non-operation read stands in for the readback, or the transfer is already enabled.
- R7: Every ignored enabling write sets status bit 31. Only a status write with bit 31 set clears it; a write with bit 31 clear leaves it set.
- R8: An operation write with bit 0 clear while enabled clears op_enable. On the same edge it sets both chip selects and both strobes high and keeps the register address field.
- R9: Status bits capture the inputs one cycle after they are applied: 16 xfer_req, 17 xfer_irq, 18 xfer_busy, 24 err_out_short, 25 err_in_short, 26 err_not_x4.
- R10: dma_state is registered one cycle after its inputs and also reads at status bits 1:0. It is 3 (error) if any of the three error inputs or xfer_irq is set. Otherwise it is 2 (interrupt) if dev_intrq is high. Otherwise it is 1 (active) if xfer_busy or xfer_req is set. Otherwise it is 0.
- R11: When wr_en and rd_en are high together, only the write takes place and rvalid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, held until the next read |
| rvalid | output | 1 | Read data valid, one cycle after a read |
| xfer_req | input | 1 | Transfer engine data request |
| xfer_irq | input | 1 | Transfer engine internal error interrupt |
| xfer_busy | input | 1 | Transfer engine not idle |
| err_out_short | input | 1 | Outbound transfer not completed |
| err_in_short | input | 1 | Inbound transfer not completed |
| err_not_x4 | input | 1 | Transfer amount not a multiple of four 32-bit words |
| dev_intrq | input | 1 | Device interrupt pin |
| op_enable | output | 1 | Transfer enabled |
| op_to_device | output | 1 | Transfer direction, 1 = toward the device |
| dma_state | output | 2 | Condensed state: 0 idle, 1 active, 2 interrupt, 3 error |
| ata_cs_n | output | 2 | Chip selects, active low |
| ata_da | output | DA_W | Device register address |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| cfg_flags | output | 4 | Enable, PIO, multiword, Ultra flags |
| cfg_mode | output | MODE_W | Mode number |
| cfg_hold | output | HOLD_W | Write data hold count |

## Verification
The bench builds the block at its default parameters: ADDR_W=4, MODE_W=4, HOLD_W=2 and DA_W=3. With those values the whole 16-byte address space is decoded, so unmapped offsets are reached and shown to read zero and to drop writes. The field positions stated in R3 and R4 are also the ones exercised. The default widths let an all-ones configuration write prove that bits above 9 are discarded. They also let each arming violation in R6 be driven on its own, followed by the error-flag clear behaviour.

// File: rtl/udma_regs_pkg.sv
package udma_regs_pkg;

  localparam int REG_W = 32;

  // register byte offsets
  localparam int OFF_CTRL = 0;
  localparam int OFF_CFG  = 4;
  localparam int OFF_OP   = 8;
  localparam int OFF_STAT = 12;

  // operation register
  localparam int OP_EN_B  = 0;
  localparam int OP_DIR_B = 1;

  // control register (fixed part)
  localparam int CTRL_CS0_B  = 0;
  localparam int CTRL_CS1_B  = 1;
  localparam int CTRL_DA_LSB = 2;
  localparam int CTRL_IRQ_B  = 9;

  // configuration register (fixed part)
  localparam int CFG_FLAG_W   = 4;
  localparam int CFG_MODE_LSB = 4;

  // status register
  localparam int ST_CODE_LSB = 0;
  localparam int ST_REQ_B    = 16;
  localparam int ST_IRQ_B    = 17;
  localparam int ST_BUSY_B   = 18;
  localparam int ST_NDO_B    = 24;
  localparam int ST_NDI_B    = 25;
  localparam int ST_N4X_B    = 26;
  localparam int ST_SEQ_B    = 31;

  typedef enum logic [1:0] {
    DST_IDLE   = 2'd0,
    DST_ACTIVE = 2'd1,
    DST_INTR   = 2'd2,
    DST_ERROR  = 2'd3
  } dma_state_e;

  typedef enum logic [1:0] {
    ARM_IDLE  = 2'd0,
    ARM_DIR   = 2'd1,
    ARM_READY = 2'd2
  } arm_state_e;

  typedef struct packed {
    logic n4x;
    logic ndi;
    logic ndo;
    logic busy;
    logic irq;
    logic req;
  } xfer_flags_t;

endpackage

// File: rtl/udma_arm_seq.sv
module udma_arm_seq
  import udma_regs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic op_wr,
  input  logic op_rd,
  input  logic wr_en_bit,
  input  logic wr_dir_bit,
  output logic enable_q,
  output logic dir_q,
  output logic arm_ready,
  output logic seq_violation,
  output logic stop_req
);

  arm_state_e state_q;
  logic       accept;

  always_comb begin
    accept        = op_wr && wr_en_bit && (state_q == ARM_READY)
                    && (wr_dir_bit == dir_q) && !enable_q;
    seq_violation = op_wr && wr_en_bit && !accept;
    stop_req      = op_wr && !wr_en_bit && enable_q;
    arm_ready     = (state_q == ARM_READY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ARM_IDLE;
      enable_q <= 1'b0;
      dir_q    <= 1'b0;
    end else if (op_wr) begin
      if (!wr_en_bit) begin
        // direction step: also stops a running transfer
        enable_q <= 1'b0;
        dir_q    <= wr_dir_bit;
        state_q  <= ARM_DIR;
      end else begin
        state_q <= ARM_IDLE;
        if (accept) enable_q <= 1'b1;
      end
    end else if (op_rd && state_q == ARM_DIR) begin
      state_q <= ARM_READY;
    end
  end

endmodule

// File: rtl/udma_status_cond.sv
module udma_status_cond
  import udma_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  xfer_flags_t flags_in,
  input  logic        intrq_in,
  output xfer_flags_t flags_q,
  output logic        intrq_q,
  output logic [1:0]  state_q
);

  function automatic dma_state_e condense(xfer_flags_t f, logic pin);
    if (f.ndo || f.ndi || f.n4x || f.irq) return DST_ERROR;
    else if (pin)                          return DST_INTR;
    else if (f.busy || f.req)              return DST_ACTIVE;
    else                                   return DST_IDLE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      intrq_q <= 1'b0;
      state_q <= DST_IDLE;
    end else begin
      flags_q <= flags_in;
      intrq_q <= intrq_in;
      state_q <= condense(flags_in, intrq_in);
    end
  end

endmodule

// File: rtl/udma_port_regs.sv
module udma_port_regs
  import udma_regs_pkg::*;
#(
  parameter int MODE_W = 4,
  parameter int HOLD_W = 2,
  parameter int DA_W   = 3,
  localparam int RD_B     = CTRL_DA_LSB + DA_W,
  localparam int WR_B     = RD_B + 1,
  localparam int HOLD_LSB = CFG_MODE_LSB + MODE_W,
  localparam int CFG_TOP  = HOLD_LSB + HOLD_W - 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [WR_B:0]     ctrl_wdata,
  input  logic              force_idle,
  input  logic              cfg_wr,
  input  logic [CFG_TOP:0]  cfg_wdata,
  output logic [1:0]        cs_n_q,
  output logic [DA_W-1:0]   da_q,
  output logic              rd_n_q,
  output logic              wr_n_q,
  output logic [CFG_FLAG_W-1:0] flags_q,
  output logic [MODE_W-1:0] mode_q,
  output logic [HOLD_W-1:0] hold_q
);

  // device-bus control lines; a stop returns them to idle
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_q <= 2'b11;
      da_q   <= '0;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
    end else if (force_idle) begin
      cs_n_q <= 2'b11;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
    end else if (ctrl_wr) begin
      cs_n_q <= {ctrl_wdata[CTRL_CS1_B], ctrl_wdata[CTRL_CS0_B]};
      da_q   <= ctrl_wdata[CTRL_DA_LSB +: DA_W];
      rd_n_q <= ctrl_wdata[RD_B];
      wr_n_q <= ctrl_wdata[WR_B];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mode_q  <= '0;
      hold_q  <= '0;
    end else if (cfg_wr) begin
      flags_q <= cfg_wdata[CFG_FLAG_W-1:0];
      mode_q  <= cfg_wdata[CFG_MODE_LSB +: MODE_W];
      hold_q  <= cfg_wdata[HOLD_LSB +: HOLD_W];
    end
  end

endmodule

// File: rtl/udma_opstat_regs.sv
module udma_opstat_regs
  import udma_regs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int MODE_W = 4,
  parameter int HOLD_W = 2,
  parameter int DA_W   = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  input  logic              xfer_req,
  input  logic              xfer_irq,
  input  logic              xfer_busy,
  input  logic              err_out_short,
  input  logic              err_in_short,
  input  logic              err_not_x4,
  input  logic              dev_intrq,
  output logic              op_enable,
  output logic              op_to_device,
  output logic [1:0]        dma_state,
  output logic [1:0]        ata_cs_n,
  output logic [DA_W-1:0]   ata_da,
  output logic              ata_rd_n,
  output logic              ata_wr_n,
  output logic [3:0]        cfg_flags,
  output logic [MODE_W-1:0] cfg_mode,
  output logic [HOLD_W-1:0] cfg_hold
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_OP   = ADDR_W'(OFF_OP);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam int RD_B     = CTRL_DA_LSB + DA_W;
  localparam int WR_B     = RD_B + 1;
  localparam int HOLD_LSB = CFG_MODE_LSB + MODE_W;
  localparam int CFG_TOP  = HOLD_LSB + HOLD_W - 1;

  logic        rd_go, wr_ctrl, wr_cfg, wr_op, wr_stat, rd_op;
  logic        arm_ready, seq_violation, stop_req, seq_err_q;
  xfer_flags_t flags_raw, flags_q;
  logic        intrq_q;
  logic [31:0] rd_word;
  wire         unused_ok = &{1'b0, wdata};

  // a write wins over a read in the same cycle
  always_comb begin
    rd_go   = rd_en && !wr_en;
    wr_ctrl = wr_en && (addr == A_CTRL);
    wr_cfg  = wr_en && (addr == A_CFG);
    wr_op   = wr_en && (addr == A_OP);
    wr_stat = wr_en && (addr == A_STAT);
    rd_op   = rd_go && (addr == A_OP);
  end

  udma_arm_seq u_arm (
    .clk          (clk),
    .rst          (rst),
    .op_wr        (wr_op),
    .op_rd        (rd_op),
    .wr_en_bit    (wdata[OP_EN_B]),
    .wr_dir_bit   (wdata[OP_DIR_B]),
    .enable_q     (op_enable),
    .dir_q        (op_to_device),
    .arm_ready    (arm_ready),
    .seq_violation(seq_violation),
    .stop_req     (stop_req)
  );

  udma_port_regs #(
    .MODE_W(MODE_W),
    .HOLD_W(HOLD_W),
    .DA_W  (DA_W)
  ) u_port (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (wr_ctrl),
    .ctrl_wdata(wdata[WR_B:0]),
    .force_idle(stop_req),
    .cfg_wr    (wr_cfg),
    .cfg_wdata (wdata[CFG_TOP:0]),
    .cs_n_q    (ata_cs_n),
    .da_q      (ata_da),
    .rd_n_q    (ata_rd_n),
    .wr_n_q    (ata_wr_n),
    .flags_q   (cfg_flags),
    .mode_q    (cfg_mode),
    .hold_q    (cfg_hold)
  );

  always_comb begin
    flags_raw.n4x  = err_not_x4;
    flags_raw.ndi  = err_in_short;
    flags_raw.ndo  = err_out_short;
    flags_raw.busy = xfer_busy;
    flags_raw.irq  = xfer_irq;
    flags_raw.req  = xfer_req;
  end

  udma_status_cond u_stat (
    .clk     (clk),
    .rst     (rst),
    .flags_in(flags_raw),
    .intrq_in(dev_intrq),
    .flags_q (flags_q),
    .intrq_q (intrq_q),
    .state_q (dma_state)
  );

  // sticky arming-order error, cleared by writing one
  always_ff @(posedge clk) begin
    if (rst)                          seq_err_q <= 1'b0;
    else if (seq_violation)           seq_err_q <= 1'b1;
    else if (wr_stat && wdata[ST_SEQ_B]) seq_err_q <= 1'b0;
  end

  always_comb begin
    rd_word = '0;
    case (addr)
      A_CTRL: begin
        rd_word[CTRL_CS0_B]              = ata_cs_n[0];
        rd_word[CTRL_CS1_B]              = ata_cs_n[1];
        rd_word[CTRL_DA_LSB +: DA_W]     = ata_da;
        rd_word[RD_B]                    = ata_rd_n;
        rd_word[WR_B]                    = ata_wr_n;
        rd_word[CTRL_IRQ_B]              = intrq_q;
      end
      A_CFG: begin
        rd_word[CFG_FLAG_W-1:0]          = cfg_flags;
        rd_word[CFG_MODE_LSB +: MODE_W]  = cfg_mode;
        rd_word[HOLD_LSB +: HOLD_W]      = cfg_hold;
      end
      A_OP: begin
        rd_word[OP_EN_B]                 = op_enable;
        rd_word[OP_DIR_B]                = op_to_device;
      end
      A_STAT: begin
        rd_word[ST_CODE_LSB +: 2]        = dma_state;
        rd_word[ST_REQ_B]                = flags_q.req;
        rd_word[ST_IRQ_B]                = flags_q.irq;
        rd_word[ST_BUSY_B]               = flags_q.busy;
        rd_word[ST_NDO_B]                = flags_q.ndo;
        rd_word[ST_NDI_B]                = flags_q.ndi;
        rd_word[ST_N4X_B]                = flags_q.n4x;
        rd_word[ST_SEQ_B]                = seq_err_q;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_go;
      if (rd_go) rdata <= rd_word;
    end
  end

endmodule

// File: rtl/udma_opstat_chk.sv
module udma_opstat_chk
  import udma_regs_pkg::*;
#(
  parameter int ADDR_W = 4
)(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              rvalid,
  input logic              op_enable,
  input logic              op_to_device,
  input logic [1:0]        dma_state,
  input logic [1:0]        ata_cs_n,
  input logic              ata_rd_n,
  input logic              ata_wr_n,
  input logic              xfer_req,
  input logic              xfer_irq,
  input logic              xfer_busy,
  input logic              err_out_short,
  input logic              err_in_short,
  input logic              err_not_x4,
  input logic              dev_intrq,
  input logic              arm_ready,
  input logic              seq_err_q
);

  localparam logic [ADDR_W-1:0] A_OP   = ADDR_W'(OFF_OP);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

  // R5
  arm_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_OP && wdata[0] && arm_ready && wdata[1] == op_to_device)
    |=> op_enable);

  // R6
  arm_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_OP && wdata[0] && !arm_ready && !op_enable)
    |=> !op_enable);

  // R7
  seq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_OP && wdata[0] && !arm_ready) |=> seq_err_q);

  // R7
  seq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_err_q && !(wr_en && addr == A_STAT && wdata[31])) |=> seq_err_q);

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_OP && !wdata[0] && op_enable)
    |=> (!op_enable && ata_rd_n && ata_wr_n && ata_cs_n == 2'b11));

  // R10
  err_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (err_out_short || err_in_short || err_not_x4 || xfer_irq)
    |=> dma_state == 2'd3);

  // R10
  idle_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!err_out_short && !err_in_short && !err_not_x4 && !xfer_irq &&
     !dev_intrq && !xfer_busy && !xfer_req) |=> dma_state == 2'd0);

  // R2
  read_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> rvalid);

  // R11
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !rvalid);

endmodule

bind udma_opstat_regs udma_opstat_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_udma_opstat_regs.sv
module tb_udma_opstat_regs;

  localparam int ADDR_W = 4;
  localparam int MODE_W = 4;
  localparam int HOLD_W = 2;
  localparam int DA_W   = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              rvalid;
  logic              xfer_req = 0, xfer_irq = 0, xfer_busy = 0;
  logic              err_out_short = 0, err_in_short = 0, err_not_x4 = 0;
  logic              dev_intrq = 0;
  logic              op_enable, op_to_device;
  logic [1:0]        dma_state;
  logic [1:0]        ata_cs_n;
  logic [DA_W-1:0]   ata_da;
  logic              ata_rd_n, ata_wr_n;
  logic [3:0]        cfg_flags;
  logic [MODE_W-1:0] cfg_mode;
  logic [HOLD_W-1:0] cfg_hold;

  udma_opstat_regs #(.ADDR_W(ADDR_W), .MODE_W(MODE_W), .HOLD_W(HOLD_W), .DA_W(DA_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .xfer_req(xfer_req), .xfer_irq(xfer_irq),
    .xfer_busy(xfer_busy), .err_out_short(err_out_short), .err_in_short(err_in_short),
    .err_not_x4(err_not_x4), .dev_intrq(dev_intrq), .op_enable(op_enable),
    .op_to_device(op_to_device), .dma_state(dma_state), .ata_cs_n(ata_cs_n),
    .ata_da(ata_da), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .cfg_flags(cfg_flags),
    .cfg_mode(cfg_mode), .cfg_hold(cfg_hold));

  localparam logic [3:0] CTRL = 4'h0, CFG = 4'h4, OP = 4'h8, STAT = 4'hC;

  int          n_vec = 0;
  int          n_bad = 0;
  bit          done  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rvalid === 1'b1) begin
      if (exp_q.size() == 0) check("R11 rvalid without pending read", 32'd1, 32'd0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic rd(logic [3:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(logic req, logic irq, logic busy, logic ndo, logic ndi,
                       logic n4x, logic pin);
    @(negedge clk);
    xfer_req = req; xfer_irq = irq; xfer_busy = busy;
    err_out_short = ndo; err_in_short = ndi; err_not_x4 = n4x; dev_intrq = pin;
  endtask

  task automatic state_case(logic req, logic irq, logic busy, logic ndo, logic ndi,
                            logic n4x, logic pin, logic [1:0] st, logic [31:0] sword,
                            string tag);
    drive(req, irq, busy, ndo, ndi, n4x, pin);
    @(negedge clk);
    check({tag, " dma_state"}, {30'd0, dma_state}, {30'd0, st});
    rd(STAT, sword, {tag, " status word"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 op_enable", {31'd0, op_enable}, 32'd0);
    check("R1 op_to_device", {31'd0, op_to_device}, 32'd0);
    check("R1 dma_state", {30'd0, dma_state}, 32'd0);
    check("R1 ctrl ports", {25'd0, ata_wr_n, ata_rd_n, ata_da, ata_cs_n}, 32'h63);
    check("R1 cfg ports", {22'd0, cfg_hold, cfg_mode, cfg_flags}, 32'd0);
    rd(CTRL, 32'h63, "R1 ctrl reset");
    rd(CFG,  32'h0,  "R1 cfg reset");
    rd(OP,   32'h0,  "R1 op reset");
    rd(STAT, 32'h0,  "R1 status reset");

    // R2 unmapped addresses
    rd(4'h1, 32'h0, "R2 unmapped read");
    wr(4'h5, 32'hFFFF_FFFF);
    rd(CFG, 32'h0, "R2 unmapped write ignored");

    // R3 control fields
    wr(CTRL, 32'h55);
    check("R3 cs_n", {30'd0, ata_cs_n}, 32'h1);
    check("R3 da", {29'd0, ata_da}, 32'h5);
    check("R3 rd_n", {31'd0, ata_rd_n}, 32'h0);
    check("R3 wr_n", {31'd0, ata_wr_n}, 32'h1);
    rd(CTRL, 32'h55, "R3 ctrl readback");
    dev_intrq = 1'b1;
    rd(CTRL, 32'h255, "R3 intrq bit 9");
    dev_intrq = 1'b0;

    // R4 config fields
    wr(CFG, 32'hFFFF_FFFF);
    rd(CFG, 32'h3FF, "R4 cfg upper bits dropped");
    wr(CFG, 32'h1A5);
    check("R4 flags", {28'd0, cfg_flags}, 32'h5);
    check("R4 mode", {28'd0, cfg_mode}, 32'hA);
    check("R4 hold", {30'd0, cfg_hold}, 32'h1);

    // R5 arming order
    wr(OP, 32'h2);
    check("R5 dir after step 1", {31'd0, op_to_device}, 32'd1);
    check("R5 not enabled after step 1", {31'd0, op_enable}, 32'd0);
    rd(OP, 32'h2, "R5 readback step");
    wr(OP, 32'h3);
    check("R5 enabled", {31'd0, op_enable}, 32'd1);
    rd(OP, 32'h3, "R5 op readback enabled");

    // R8 stop returns bus to idle, keeps address
    wr(CTRL, 32'h08);
    wr(OP, 32'h0);
    check("R8 stopped", {31'd0, op_enable}, 32'd0);
    check("R8 ctrl idle", {25'd0, ata_wr_n, ata_rd_n, ata_da, ata_cs_n}, 32'h6B);
    rd(CTRL, 32'h6B, "R8 ctrl readback");

    // R6 violations (state after stop: direction step done, no read)
    wr(OP, 32'h1);
    check("R6 no readback", {31'd0, op_enable}, 32'd0);
    rd(STAT, 32'h8000_0000, "R7 seq error set");
    wr(OP, 32'h2); rd(OP, 32'h2, "R6 readback"); wr(OP, 32'h1);
    check("R6 direction mismatch", {31'd0, op_enable}, 32'd0);
    rd(OP, 32'h2, "R6 read without direction write"); wr(OP, 32'h3);
    check("R6 read alone", {31'd0, op_enable}, 32'd0);
    wr(OP, 32'h0); rd(CFG, 32'h1A5, "R6 other read"); wr(OP, 32'h1);
    check("R6 foreign read", {31'd0, op_enable}, 32'd0);

    // R7 clear behaviour
    wr(STAT, 32'h0);
    rd(STAT, 32'h8000_0000, "R7 zero write keeps flag");
    wr(STAT, 32'h8000_0000);
    rd(STAT, 32'h0, "R7 cleared");

    // R6 enable while enabled
    wr(OP, 32'h0); rd(OP, 32'h0, "R5 readback dir 0"); wr(OP, 32'h1);
    check("R5 enabled dir 0", {30'd0, op_to_device, op_enable}, 32'h1);
    wr(OP, 32'h1);
    check("R6 re-enable keeps enable", {31'd0, op_enable}, 32'd1);
    rd(STAT, 32'h8000_0000, "R7 re-enable flags error");
    wr(OP, 32'h0);
    wr(STAT, 32'h8000_0000);

    // R10 latency
    drive(0, 0, 1, 0, 0, 0, 0);
    check("R10 before edge", {30'd0, dma_state}, 32'd0);
    @(negedge clk);
    check("R10 one cycle", {30'd0, dma_state}, 32'd1);

    // R9 / R10 patterns
    state_case(0, 0, 1, 0, 0, 0, 0, 2'd1, 32'h0004_0001, "R9 R10 busy");
    state_case(1, 0, 0, 0, 0, 0, 0, 2'd1, 32'h0001_0001, "R9 R10 request");
    state_case(0, 0, 1, 0, 0, 0, 1, 2'd2, 32'h0004_0002, "R10 intr over active");
    state_case(0, 0, 1, 1, 0, 0, 1, 2'd3, 32'h0104_0003, "R10 out short");
    state_case(0, 0, 0, 0, 1, 0, 0, 2'd3, 32'h0200_0003, "R9 R10 in short");
    state_case(0, 0, 0, 0, 0, 1, 1, 2'd3, 32'h0400_0003, "R9 R10 not x4");
    state_case(0, 1, 0, 0, 0, 0, 0, 2'd3, 32'h0002_0003, "R9 R10 engine irq");
    state_case(0, 0, 0, 0, 0, 0, 0, 2'd0, 32'h0,         "R10 idle");

    // R11 write and read together
    @(negedge clk);
    addr = CFG; wdata = 32'h22; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R11 no rvalid", {31'd0, rvalid}, 32'd0);
    check("R11 write done", {22'd0, cfg_hold, cfg_mode, cfg_flags}, 32'h22);

    repeat (3) @(negedge clk);
    check("R2 all reads returned", exp_q.size(), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule